// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel for an event timer. A free-running main counter comes in as an input. The channel flags an event when that counter arrives at a programmed compare value. Each event sets a status bit. It can also raise an interrupt, either as a one-cycle pulse or as a level that stays high until software clears the status. The compare width is set by a parameter and is 32 or 64 bits.

The channel has two modes. In one-shot mode the compare value stays where software put it. In periodic mode the channel adds the last-written value to the comparator after every event, so events repeat at a fixed spacing. The sum wraps modulo 2^WIDTH. A parameter decides whether the channel is able to run in periodic mode at all.

Software reaches the channel through a simple write/read port that has two locations. The status-clear strobe comes from a shared status register that lives outside this block. The interrupt output is driven by a three-state machine:

- IRQ_IDLE: the output is low.
- IRQ_PULSE: the output is high for one cycle. This is edge style.
- IRQ_HELD: the output is held high. This is level style.

The transitions are:

- Both IRQ_IDLE and IRQ_PULSE go to IRQ_PULSE (edge style) or to IRQ_HELD (level style) on an enabled event. Otherwise they return to IRQ_IDLE.
- IRQ_HELD returns to IRQ_IDLE in either of two cases. The first is a status clear with no event in the same cycle. The second is software clearing the enable bit or the level bit.
- In every other case, IRQ_HELD stays where it is.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset, the configuration word reads 0 and the comparator reads all ones in its WIDTH bits (32'hFFFFFFFF for WIDTH=32). Both irq and sts are low.
- R2: Select 0 is the configuration word and select 1 is the comparator. In the configuration word, bit 0 is the interrupt enable, bit 1 selects level style (1) or edge style (0), and bit 2 selects periodic mode. All higher bits read as 0 whatever was written to them.
- R3: An event happens on a clock edge at which main_count equals the comparator and differs from its value at the previous edge. A counter that holds at the compare value for several cycles therefore gives exactly one event.
- R4: Every event sets sts, whether or not the interrupt is enabled. A sts_clr strobe clears sts at the next edge. If an event coincides with the strobe, sts stays set.
- R5: While the interrupt enable is 0, irq stays low, but events still set sts.
- R6: In edge style, irq goes high for exactly one cycle, in the cycle after the edge that saw the event.
- R7: In level style, irq rises in the cycle after an event and stays high until the edge after a sts_clr that has no coincident event. A further event before the clear keeps irq high and does not restart anything.
- R8: In one-shot mode, an event leaves the comparator unchanged.
- R9: In periodic mode, each event adds the last value written to the comparator onto the comparator. Writing 0x123 gives events at 0x123, then 0x246, then 0x369.
- R10: The periodic addition wraps modulo 2^WIDTH. With WIDTH=32, a comparator of 0xC0000000 plus a period of 0xC0000000 becomes 0x80000000.
- R11: With PERIODIC_CAPABLE=0, configuration bit 2 reads 0 and the comparator never advances.
- R12: A write to the comparator loads both the live compare value and the hidden period. A read of the comparator returns its current live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_count | input | WIDTH | Free-running main counter value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 comparator |
| wr_data | input | WIDTH | Write data |
| rd_sel | input | 1 | Read target: 0 configuration, 1 comparator |
| rd_data | output | WIDTH | Read data, combinational |
| sts_clr | input | 1 | Status clear strobe from the shared status register |
| sts | output | 1 | Event status bit |
| irq | output | 1 | Interrupt output |

## Verification
The assertions watch several properties on every cycle:

- An event always sets sts.
- A lone clear drops sts.
- A cleared enable forces irq low.
- An edge pulse never lasts past one cycle unless a new event arrives.
- A held level survives until it is cleared.
- A one-shot comparator never moves without a write.
- A periodic comparator moves by exactly the period.

The bench scenarios are what show the concrete values:

- The reset contents.
- The masking of reserved configuration bits.
- The specific periodic sequence.
- The wrapped sum.
- That a steady counter gives one event.
- That a channel built without periodic capability ignores the periodic bit.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_PULSE = 2'd1,
        IRQ_HELD  = 2'd2
    } irq_state_e;

    localparam int CFG_EN_BIT    = 0;
    localparam int CFG_LEVEL_BIT = 1;
    localparam int CFG_PER_BIT   = 2;
    localparam int CFG_BITS      = 3;

    localparam logic SEL_CFG = 1'b0;
    localparam logic SEL_CMP = 1'b1;

endpackage

// File: rtl/evtc_regs.sv
module evtc_regs
    import evtc_pkg::*;
#(
    parameter int WIDTH            = 32,
    parameter bit PERIODIC_CAPABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_sel,
    input  logic             hit,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] cmp_val,
    output logic             int_en,
    output logic             lvl_mode
);

    localparam int PAD_BITS = WIDTH - CFG_BITS;

    logic [WIDTH-1:0] cmp_q;
    logic [WIDTH-1:0] period_q;
    logic             en_q;
    logic             lvl_q;
    logic             per_q;
    logic             cfg_wr;
    logic             cmp_wr;

    assign cfg_wr = wr_en && (wr_sel == SEL_CFG);
    assign cmp_wr = wr_en && (wr_sel == SEL_CMP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            lvl_q <= 1'b0;
        end else if (cfg_wr) begin
            en_q  <= wr_data[CFG_EN_BIT];
            lvl_q <= wr_data[CFG_LEVEL_BIT];
        end
    end

    generate
        if (PERIODIC_CAPABLE) begin : g_periodic
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    per_q <= 1'b0;
                else if (cfg_wr)
                    per_q <= wr_data[CFG_PER_BIT];
            end
        end else begin : g_oneshot_only
            assign per_q = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q    <= '1;
            period_q <= '1;
        end else if (cmp_wr) begin
            cmp_q    <= wr_data;
            period_q <= wr_data;
        end else if (hit && per_q) begin
            cmp_q    <= cmp_q + period_q;
        end
    end

    always_comb begin
        if (rd_sel == SEL_CMP)
            rd_data = cmp_q;
        else
            rd_data = {{PAD_BITS{1'b0}}, per_q, lvl_q, en_q};
    end

    assign cmp_val  = cmp_q;
    assign int_en   = en_q;
    assign lvl_mode = lvl_q;

    // R8
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_wr && !per_q) |=> $stable(cmp_q));

    // R9
    periodic_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && per_q && !cmp_wr) |=> (cmp_q == WIDTH'($past(cmp_q) + $past(period_q))));

endmodule

// File: rtl/evtc_match.sv
module evtc_match #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] main_count,
    input  logic [WIDTH-1:0] cmp_val,
    input  logic             sts_clr,
    output logic             hit,
    output logic             sts
);

    logic [WIDTH-1:0] count_q;
    logic             sts_q;

    assign hit = (main_count == cmp_val) && (main_count != count_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= main_count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sts_q <= 1'b0;
        else if (hit)
            sts_q <= 1'b1;
        else if (sts_clr)
            sts_q <= 1'b0;
    end

    assign sts = sts_q;

    // R4
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> sts);

    // R4
    sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !hit) |=> !sts);

    // R3
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!$stable(main_count) || !hit));

endmodule

// File: rtl/evtc_irq_fsm.sv
module evtc_irq_fsm
    import evtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic sts_clr,
    input  logic int_en,
    input  logic lvl_mode,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE, IRQ_PULSE: begin
                if (hit && int_en)
                    state_d = lvl_mode ? IRQ_HELD : IRQ_PULSE;
                else
                    state_d = IRQ_IDLE;
            end
            IRQ_HELD: begin
                if (!int_en || !lvl_mode)
                    state_d = IRQ_IDLE;
                else if (sts_clr && !hit)
                    state_d = IRQ_IDLE;
                else
                    state_d = IRQ_HELD;
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q != IRQ_IDLE);
    end

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> !irq);

    // R6
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !lvl_mode && !hit) |=> !irq);

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_HELD && int_en && lvl_mode && !sts_clr) |=> irq);

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evtc_pkg::*;
#(
    parameter int WIDTH            = 32,
    parameter bit PERIODIC_CAPABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] main_count,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_sel,
    output logic [WIDTH-1:0] rd_data,
    input  logic             sts_clr,
    output logic             sts,
    output logic             irq
);

    logic [WIDTH-1:0] cmp_val;
    logic             hit;
    logic             int_en;
    logic             lvl_mode;

    evtc_regs #(
        .WIDTH            (WIDTH),
        .PERIODIC_CAPABLE (PERIODIC_CAPABLE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .hit      (hit),
        .rd_data  (rd_data),
        .cmp_val  (cmp_val),
        .int_en   (int_en),
        .lvl_mode (lvl_mode)
    );

    evtc_match #(
        .WIDTH (WIDTH)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .main_count (main_count),
        .cmp_val    (cmp_val),
        .sts_clr    (sts_clr),
        .hit        (hit),
        .sts        (sts)
    );

    evtc_irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .sts_clr  (sts_clr),
        .int_en   (int_en),
        .lvl_mode (lvl_mode),
        .irq      (irq)
    );

    // R5
    masked_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !int_en) |=> (sts && !irq));

endmodule

// File: tb/test_evt_cmp_channel.sv
module test_evt_cmp_channel;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] main_count = '0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_sel = 1'b0;
    logic         sts_clr = 1'b0;
    logic [W-1:0] rd_data, rd_data_np;
    logic         sts, irq, sts_np, irq_np;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evt_cmp_channel #(.WIDTH(W), .PERIODIC_CAPABLE(1'b1)) i_evt_cmp_channel (
        .clk(clk), .rst_n(rst_n), .main_count(main_count),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .sts_clr(sts_clr), .sts(sts), .irq(irq)
    );

    evt_cmp_channel #(.WIDTH(W), .PERIODIC_CAPABLE(1'b0)) i_evt_cmp_channel_np (
        .clk(clk), .rst_n(rst_n), .main_count(main_count),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data_np),
        .sts_clr(sts_clr), .sts(sts_np), .irq(irq_np)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [W-1:0] val, output logic [W-1:0] val_np);
        rd_sel = sel;
        #1;
        val = rd_data;
        val_np = rd_data_np;
    endtask

    task automatic set_count(input logic [W-1:0] v);
        @(negedge clk);
        main_count = v;
    endtask

    task automatic clr();
        @(negedge clk);
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    task automatic t_reset();
        logic [W-1:0] v, vn;
        chk("R1 irq", irq, 0);
        chk("R1 sts", sts, 0);
        rd(1'b0, v, vn);
        chk("R1 cfg", v, 0);
        rd(1'b1, v, vn);
        chk("R1 cmp", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_oneshot_edge();
        logic [W-1:0] v, vn;
        wr(1'b0, 32'h1);
        wr(1'b1, 32'd10);
        set_count(9);
        set_count(10);
        @(negedge clk);
        chk("R6 pulse high", irq, 1);
        chk("R4 sts set", sts, 1);
        @(negedge clk);
        chk("R6 pulse one cycle", irq, 0);
        rd(1'b1, v, vn);
        chk("R8 cmp unchanged", v, 10);
        set_count(11);
        @(negedge clk);
        chk("R8 no further event", irq, 0);
    endtask

    task automatic t_held_count();
        clr();
        chk("R4 sts cleared", sts, 0);
        wr(1'b1, 32'd50);
        set_count(49);
        set_count(50);
        @(negedge clk);
        chk("R3 first event", irq, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 held count no event", irq, 0);
        end
        clr();
        chk("R3 held count no new status", sts, 0);
    endtask

    task automatic t_disabled();
        wr(1'b0, 32'h0);
        clr();
        wr(1'b1, 32'd20);
        set_count(19);
        set_count(20);
        @(negedge clk);
        chk("R5 irq masked", irq, 0);
        chk("R5 sts still set", sts, 1);
        @(negedge clk);
        chk("R5 irq masked later", irq, 0);
    endtask

    task automatic t_level();
        wr(1'b0, 32'h3);
        clr();
        wr(1'b1, 32'd30);
        set_count(29);
        set_count(30);
        @(negedge clk);
        chk("R7 level rises", irq, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7 level held", irq, 1);
        end
        set_count(29);
        set_count(30);
        @(negedge clk);
        chk("R7 repeat keeps high", irq, 1);
        chk("R7 repeat sts", sts, 1);
        clr();
        chk("R7 level drops on clear", irq, 0);
        chk("R4 sts cleared", sts, 0);
    endtask

    task automatic t_clear_collide();
        set_count(29);
        set_count(30);
        @(negedge clk);
        chk("R7 level rises again", irq, 1);
        set_count(29);
        @(negedge clk);
        main_count = 30;
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
        chk("R4 collide keeps sts", sts, 1);
        chk("R7 collide keeps irq", irq, 1);
        clr();
        chk("R7 final clear", irq, 0);
    endtask

    task automatic t_periodic();
        logic [W-1:0] v, vn;
        wr(1'b0, 32'h5);
        rd(1'b0, v, vn);
        chk("R2 cfg periodic", v, 5);
        chk("R11 cfg bit2 reads 0", vn, 1);
        wr(1'b1, 32'h123);
        rd(1'b1, v, vn);
        chk("R12 cmp readback", v, 32'h123);
        set_count(32'h122);
        set_count(32'h123);
        @(negedge clk);
        chk("R9 first event", irq, 1);
        rd(1'b1, v, vn);
        chk("R9 advanced once", v, 32'h246);
        chk("R11 no advance", vn, 32'h123);
        set_count(32'h245);
        set_count(32'h246);
        @(negedge clk);
        chk("R9 second event", irq, 1);
        chk("R11 no event at advanced value", irq_np, 0);
        rd(1'b1, v, vn);
        chk("R9 advanced twice", v, 32'h369);
    endtask

    task automatic t_wrap();
        logic [W-1:0] v, vn;
        wr(1'b1, 32'hC000_0000);
        set_count(32'hBFFF_FFFF);
        set_count(32'hC000_0000);
        @(negedge clk);
        chk("R10 event", irq, 1);
        rd(1'b1, v, vn);
        chk("R10 wrapped sum", v, 32'h8000_0000);
    endtask

    task automatic t_reserved();
        logic [W-1:0] v, vn;
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v, vn);
        chk("R2 reserved bits zero", v, 7);
        chk("R11 reserved and periodic zero", vn, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot_edge();
        t_held_count();
        t_disabled();
        t_level();
        t_clear_collide();
        t_periodic();
        t_wrap();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule